// File: doc/BRIEF.md
# Two-Wire Bus Slave Front End with Store-Busy Polling

This block is the bit-level front end of a two-wire bus slave for a multi-channel settings device. It filters and synchronizes the SCL and SDA lines against the system clock, detects start and stop conditions, and shifts in bytes on rising SCL edges. The first byte of each frame is a slave address. Its upper nibble must be a fixed type code and its lower nibble must equal four strap inputs. On a match the slave acknowledges by pulling SDA low through an open-drain enable. It never drives SDA high.

Each accepted byte goes to a command layer with a one-cycle strobe that tags it as address, command or data. After the command byte, the command layer can ask the block to send a byte back. That byte goes out MSB first, and the master then supplies its own acknowledge bit. While the command layer reports that a nonvolatile store is running, the address is not acknowledged and the rest of the frame is ignored. A host can therefore poll with the address until it sees an acknowledge.

Top module: `twi_poll_slave`

## Requirements
- R1: A start condition is SDA falling while the filtered SCL is high, and a stop condition is SDA rising while SCL is high. SDA changes while SCL is low are data and never open a frame.
- R2: The first byte after a start is accepted only when bits [7:4] equal 4'b0101 and bits [3:0] equal `strap_addr`, with `strap_addr[3]` compared against bit 7-4=3 of the byte (the MSB of the lower nibble). Otherwise the slave does not acknowledge and ignores the frame until the next start.
- R3: An accepted address, the command byte after it, and the first data byte after the command are each acknowledged. `sda_pull` is 1 for the whole ninth SCL clock, and it is raised only while SCL is low.
- R4: While `store_busy` is 1 when the eighth address bit is clocked in, the address is not acknowledged, no strobe is issued, and later bytes of that frame are ignored. Once `store_busy` is 0, a new frame to the same address is acknowledged.
- R5: After reset, and after a stop, the slave drives nothing and accepts nothing until a start condition.
- R6: If `tx_en` is 1 at the SCL fall that ends the command acknowledge, `tx_byte` is sent MSB first: `sda_pull` = 1 for a 0 bit. SDA is released during the following master acknowledge bit.
- R7: A start seen in the middle of a byte aborts that byte and restarts address reception. A stop returns the slave to idle.
- R8: Each accepted byte gives a single-cycle `rx_valid` with the byte on `rx_byte` and its position on `rx_kind`: 2'b01 address, 2'b10 command, 2'b11 data. Rejected bytes give no strobe.
- R9: Bytes after the first data byte in a write frame are not acknowledged and produce no strobe.
- R10: A pulse on SCL shorter than the filter length (default 4 clock cycles) has no effect on the received bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line as seen at the pin |
| sda_in | input | 1 | Bus data line as seen at the pin |
| strap_addr | input | 4 | Device address straps, bit 3 most significant |
| store_busy | input | 1 | Nonvolatile store in progress; address acknowledge withheld |
| tx_en | input | 1 | Command layer requests a read byte after the command |
| tx_byte | input | 8 | Byte to send on a read |
| sda_pull | output | 1 | Open-drain enable: 1 pulls SDA low |
| rx_valid | output | 1 | One-cycle strobe for an accepted byte |
| rx_byte | output | 8 | Accepted byte |
| rx_kind | output | 2 | Position of the byte in the frame |

## Verification
The assertions assume that the host drives SDA only while SCL is low, except for deliberate start and stop conditions. They also assume that no start or stop is issued while the slave itself holds SDA low, and that the straps and the busy flag do not change inside a frame. The stimulus respects these limits. It moves SDA in the middle of every SCL low phase and holds each bus phase far longer than the synchronizer and filter delay. It changes the straps, busy and read inputs only between frames, and it issues start and stop only after the slave has released the line.

// File: rtl/twi_poll_pkg.sv
package twi_poll_pkg;
  typedef enum logic [1:0] {
    KIND_NONE = 2'b00,
    KIND_ADDR = 2'b01,
    KIND_CMD  = 2'b10,
    KIND_DATA = 2'b11
  } byte_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_DECIDE,
    ST_ACK,
    ST_TX,
    ST_MACK,
    ST_SKIP
  } fsm_state_e;
endpackage

// File: rtl/twi_line_filter.sv
module twi_line_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic line_in,
  output logic line_out
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          cnt;
  logic                   synced;

  assign synced = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '1;
    else     sync_q <= {sync_q[SYNC_STAGES-2:0], line_in};
  end

  // a level is taken over only after FILT_LEN consecutive differing samples
  always_ff @(posedge clk) begin
    if (rst) begin
      line_out <= 1'b1;
      cnt      <= '0;
    end else if (synced == line_out) begin
      cnt <= '0;
    end else if (cnt == CW'(FILT_LEN - 1)) begin
      line_out <= synced;
      cnt      <= '0;
    end else begin
      cnt <= cnt + CW'(1);
    end
  end
endmodule

// File: rtl/twi_cond_detect.sv
module twi_cond_detect (
  input  logic clk,
  input  logic rst,
  input  logic scl_f,
  input  logic sda_f,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_cond,
  output logic stop_cond
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  assign scl_rise   = scl_f & ~scl_q;
  assign scl_fall   = ~scl_f & scl_q;
  assign start_cond = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_cond  = scl_f & scl_q & ~sda_q & sda_f;
endmodule

// File: rtl/twi_byte_fsm.sv
module twi_byte_fsm
  import twi_poll_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int BYTE_W = 8,
  parameter logic [BYTE_W-ADDR_W-1:0] TYPE_ID = 4'b0101
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_cond,
  input  logic              stop_cond,
  input  logic              sda_f,
  input  logic [ADDR_W-1:0] strap_addr,
  input  logic              store_busy,
  input  logic              tx_en,
  input  logic [BYTE_W-1:0] tx_byte,
  output logic              sda_low,
  output logic              rx_valid,
  output logic [BYTE_W-1:0] rx_byte,
  output byte_kind_e        rx_kind
);
  localparam int BCW = $clog2(BYTE_W);
  localparam logic [BCW-1:0] LAST_BIT = BCW'(BYTE_W - 1);

  fsm_state_e        state;
  byte_kind_e        phase;
  logic [BCW-1:0]    bit_cnt;
  logic [BYTE_W-1:0] shreg;
  logic              ack_go;

  logic [BYTE_W-1:0] next_byte;
  logic              addr_hit;
  logic              accept;

  assign next_byte = {shreg[BYTE_W-2:0], sda_f};
  assign addr_hit  = (next_byte == {TYPE_ID, strap_addr});
  assign accept    = (phase != KIND_ADDR) | (addr_hit & ~store_busy);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      phase    <= KIND_ADDR;
      bit_cnt  <= '0;
      shreg    <= '0;
      ack_go   <= 1'b0;
      sda_low  <= 1'b0;
      rx_valid <= 1'b0;
      rx_byte  <= '0;
      rx_kind  <= KIND_NONE;
    end else begin
      rx_valid <= 1'b0;
      if (start_cond) begin
        state   <= ST_RX;
        phase   <= KIND_ADDR;
        bit_cnt <= '0;
        sda_low <= 1'b0;
      end else if (stop_cond) begin
        state   <= ST_IDLE;
        sda_low <= 1'b0;
      end else begin
        case (state)
          ST_RX: if (scl_rise) begin
            shreg <= next_byte;
            if (bit_cnt == LAST_BIT) begin
              bit_cnt <= '0;
              state   <= ST_DECIDE;
              ack_go  <= accept;
              if (accept) begin
                rx_valid <= 1'b1;
                rx_byte  <= next_byte;
                rx_kind  <= phase;
              end
            end else begin
              bit_cnt <= bit_cnt + BCW'(1);
            end
          end
          ST_DECIDE: if (scl_fall) begin
            if (ack_go) begin
              sda_low <= 1'b1;
              state   <= ST_ACK;
            end else begin
              state <= ST_SKIP;
            end
          end
          ST_ACK: if (scl_fall) begin
            case (phase)
              KIND_ADDR: begin
                sda_low <= 1'b0;
                phase   <= KIND_CMD;
                state   <= ST_RX;
              end
              KIND_CMD: begin
                if (tx_en) begin
                  shreg   <= tx_byte;
                  sda_low <= ~tx_byte[BYTE_W-1];
                  bit_cnt <= '0;
                  state   <= ST_TX;
                end else begin
                  sda_low <= 1'b0;
                  phase   <= KIND_DATA;
                  state   <= ST_RX;
                end
              end
              default: begin
                sda_low <= 1'b0;
                state   <= ST_SKIP;
              end
            endcase
          end
          ST_TX: if (scl_fall) begin
            if (bit_cnt == LAST_BIT) begin
              sda_low <= 1'b0;
              state   <= ST_MACK;
            end else begin
              bit_cnt <= bit_cnt + BCW'(1);
              shreg   <= shreg << 1;
              sda_low <= ~shreg[BYTE_W-2];
            end
          end
          ST_MACK: if (scl_fall) state <= ST_SKIP;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/twi_poll_slave.sv
module twi_poll_slave
  import twi_poll_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int BYTE_W      = 8,
  parameter logic [BYTE_W-ADDR_W-1:0] TYPE_ID = 4'b0101,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic [ADDR_W-1:0] strap_addr,
  input  logic              store_busy,
  input  logic              tx_en,
  input  logic [BYTE_W-1:0] tx_byte,
  output logic              sda_pull,
  output logic              rx_valid,
  output logic [BYTE_W-1:0] rx_byte,
  output logic [1:0]        rx_kind
);
  localparam int LINES = 2;

  logic [LINES-1:0] raw_lines;
  logic [LINES-1:0] filt_lines;
  logic             scl_f, sda_f;
  logic             scl_rise, scl_fall, start_cond, stop_cond;
  byte_kind_e       kind_w;

  assign raw_lines = {sda_in, scl_in};
  assign scl_f     = filt_lines[0];
  assign sda_f     = filt_lines[1];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    twi_line_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_LEN   (FILT_LEN)
    ) u_filt (
      .clk     (clk),
      .rst     (rst),
      .line_in (raw_lines[g]),
      .line_out(filt_lines[g])
    );
  end

  twi_cond_detect u_det (
    .clk       (clk),
    .rst       (rst),
    .scl_f     (scl_f),
    .sda_f     (sda_f),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_cond(start_cond),
    .stop_cond (stop_cond)
  );

  twi_byte_fsm #(
    .ADDR_W (ADDR_W),
    .BYTE_W (BYTE_W),
    .TYPE_ID(TYPE_ID)
  ) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_cond(start_cond),
    .stop_cond (stop_cond),
    .sda_f     (sda_f),
    .strap_addr(strap_addr),
    .store_busy(store_busy),
    .tx_en     (tx_en),
    .tx_byte   (tx_byte),
    .sda_low   (sda_pull),
    .rx_valid  (rx_valid),
    .rx_byte   (rx_byte),
    .rx_kind   (kind_w)
  );

  assign rx_kind = kind_w;
endmodule

// File: rtl/twi_poll_slave_chk.sv
module twi_poll_slave_chk #(
  parameter int ADDR_W = 4,
  parameter int BYTE_W = 8,
  parameter logic [BYTE_W-ADDR_W-1:0] TYPE_ID = 4'b0101
) (
  input logic              clk,
  input logic              rst,
  input logic              scl_f,
  input logic              store_busy,
  input logic [ADDR_W-1:0] strap_addr,
  input logic              sda_pull,
  input logic              rx_valid,
  input logic [BYTE_W-1:0] rx_byte,
  input logic [1:0]        rx_kind
);
  // R3
  pull_rise_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_pull) |-> !scl_f);

  // R8
  strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  // R8
  strobe_kind_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> (rx_kind != 2'b00));

  // R2
  addr_match_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && rx_kind == 2'b01) |-> (rx_byte == {TYPE_ID, strap_addr}));

  // R4
  addr_not_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && rx_kind == 2'b01) |-> !$past(store_busy));
endmodule

bind twi_poll_slave twi_poll_slave_chk #(
  .ADDR_W (ADDR_W),
  .BYTE_W (BYTE_W),
  .TYPE_ID(TYPE_ID)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .scl_f     (scl_f),
  .store_busy(store_busy),
  .strap_addr(strap_addr),
  .sda_pull  (sda_pull),
  .rx_valid  (rx_valid),
  .rx_byte   (rx_byte),
  .rx_kind   (rx_kind)
);

// File: tb/tb_twi_poll_slave.sv
module tb_twi_poll_slave;
  localparam int Q = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scl_h = 1'b1;
  logic       sda_h = 1'b1;
  logic [3:0] strap = 4'hA;
  logic       busy = 1'b0;
  logic       tx_en = 1'b0;
  logic [7:0] tx_byte = 8'h00;
  logic       sda_pull, rx_valid;
  logic [7:0] rx_byte;
  logic [1:0] rx_kind;
  logic       sda_bus;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  // strobe log, cleared through clr_log
  logic       clr_log = 1'b0;
  int         n_strobe;
  logic [1:0] kind_log [0:7];
  logic [7:0] byte_log [0:7];

  always #10 clk = ~clk;

  assign sda_bus = sda_h & ~sda_pull;

  twi_poll_slave dut (
    .clk(clk), .rst(rst), .scl_in(scl_h), .sda_in(sda_bus),
    .strap_addr(strap), .store_busy(busy), .tx_en(tx_en), .tx_byte(tx_byte),
    .sda_pull(sda_pull), .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_kind(rx_kind)
  );

  always @(posedge clk) begin
    if (clr_log) n_strobe <= 0;
    else if (!rst && rx_valid) begin
      if (n_strobe < 8) begin
        kind_log[n_strobe] <= rx_kind;
        byte_log[n_strobe] <= rx_byte;
      end
      n_strobe <= n_strobe + 1;
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clear_log();
    clr_log = 1'b1;
    wait_cyc(1);
    clr_log = 1'b0;
  endtask

  task automatic bus_start();
    scl_h = 1'b0; wait_cyc(Q);
    sda_h = 1'b1; wait_cyc(Q);
    scl_h = 1'b1; wait_cyc(Q);
    sda_h = 1'b0; wait_cyc(Q);
    scl_h = 1'b0; wait_cyc(Q);
  endtask

  task automatic bus_stop();
    scl_h = 1'b0; wait_cyc(Q);
    sda_h = 1'b0; wait_cyc(Q);
    scl_h = 1'b1; wait_cyc(Q);
    sda_h = 1'b1; wait_cyc(2 * Q);
  endtask

  // send the top n bits of b, no acknowledge slot; optional 1-cycle SCL glitch
  task automatic send_bits(input logic [7:0] b, input int n, input int glitch_bit);
    for (int i = 7; i > 7 - n; i--) begin
      scl_h = 1'b0;
      wait_cyc(Q);
      sda_h = b[i];
      if (i == glitch_bit) begin
        scl_h = 1'b1; wait_cyc(1); scl_h = 1'b0;
      end
      wait_cyc(Q);
      scl_h = 1'b1;
      wait_cyc(2 * Q);
      scl_h = 1'b0;
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input int glitch_bit, output logic acked);
    send_bits(b, 8, glitch_bit);
    wait_cyc(Q);
    sda_h = 1'b1;
    wait_cyc(Q);
    scl_h = 1'b1;
    wait_cyc(Q);
    acked = ~sda_bus & sda_pull;
    wait_cyc(Q);
    scl_h = 1'b0;
    wait_cyc(Q);
  endtask

  task automatic read_byte(input logic master_ack, output logic [7:0] got, output logic released);
    got = 8'h00;
    sda_h = 1'b1;
    for (int i = 0; i < 8; i++) begin
      scl_h = 1'b0; wait_cyc(2 * Q);
      scl_h = 1'b1; wait_cyc(Q);
      got = {got[6:0], sda_bus};
      wait_cyc(Q);
    end
    scl_h = 1'b0; wait_cyc(Q);
    sda_h = ~master_ack; wait_cyc(Q);
    scl_h = 1'b1; wait_cyc(Q);
    released = ~sda_pull;
    wait_cyc(Q);
    scl_h = 1'b0; wait_cyc(Q);
    sda_h = 1'b1;
  endtask

  // {address byte, strap, busy, expected acknowledge}
  localparam logic [13:0] VEC [8] = '{
    {8'h5A, 4'hA, 1'b0, 1'b1},
    {8'h5A, 4'hB, 1'b0, 1'b0},
    {8'h6A, 4'hA, 1'b0, 1'b0},
    {8'h53, 4'h3, 1'b1, 1'b0},
    {8'h53, 4'h3, 1'b0, 1'b1},
    {8'hD5, 4'h5, 1'b0, 1'b0},
    {8'h50, 4'h0, 1'b0, 1'b1},
    {8'h5F, 4'hF, 1'b0, 1'b1}
  };

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic       ack;
    logic       rel;
    logic [7:0] got;

    clr_log = 1'b1;
    wait_cyc(5);
    rst = 1'b0;
    clr_log = 1'b0;
    wait_cyc(Q);

    // R5: reset state
    check("R5 pull after reset", sda_pull, 1'b0);
    check("R5 valid after reset", rx_valid, 1'b0);

    // R2/R4 vector table: address match, straps, busy
    for (int i = 0; i < 8; i++) begin
      strap = VEC[i][5:2];
      busy  = VEC[i][1];
      clear_log();
      bus_start();
      send_byte(VEC[i][13:6], -1, ack);
      check($sformatf("R2/R4 vec%0d ack", i), ack, VEC[i][0]);
      bus_stop();
      check($sformatf("R8 vec%0d strobes", i), n_strobe, VEC[i][0]);
    end
    busy = 1'b0;
    strap = 4'hA;

    // R3/R8/R9: write frame
    clear_log();
    bus_start();
    send_byte(8'h5A, -1, ack); check("R3 addr ack", ack, 1'b1);
    send_byte(8'h9C, -1, ack); check("R3 cmd ack", ack, 1'b1);
    send_byte(8'h3E, -1, ack); check("R3 data ack", ack, 1'b1);
    send_byte(8'h11, -1, ack); check("R9 extra byte no ack", ack, 1'b0);
    bus_stop();
    check("R8 write strobes", n_strobe, 3);
    check("R8 kind addr", kind_log[0], 2'b01);
    check("R8 kind cmd", kind_log[1], 2'b10);
    check("R8 kind data", kind_log[2], 2'b11);
    check("R8 cmd byte", byte_log[1], 8'h9C);
    check("R8 data byte", byte_log[2], 8'h3E);

    // R6: read frame
    tx_en = 1'b1;
    tx_byte = 8'hA5;
    clear_log();
    bus_start();
    send_byte(8'h5A, -1, ack); check("R6 addr ack", ack, 1'b1);
    send_byte(8'hB4, -1, ack); check("R6 cmd ack", ack, 1'b1);
    read_byte(1'b0, got, rel);
    check("R6 read byte", got, 8'hA5);
    check("R6 released at master ack", rel, 1'b1);
    bus_stop();
    check("R6 read strobes", n_strobe, 2);
    tx_en = 1'b0;

    // R1/R5: SDA moves with SCL low, then a byte without a start
    clear_log();
    scl_h = 1'b0; wait_cyc(Q);
    sda_h = 1'b0; wait_cyc(Q);
    sda_h = 1'b1; wait_cyc(Q);
    send_byte(8'h5A, -1, ack);
    check("R1 no frame without start", ack, 1'b0);
    check("R5 idle no strobe", n_strobe, 0);
    bus_stop();

    // R7: start in mid byte restarts address reception
    clear_log();
    bus_start();
    send_bits(8'h5A, 4, -1);
    bus_start();
    send_byte(8'h5A, -1, ack);
    check("R7 restart addr ack", ack, 1'b1);
    bus_stop();
    check("R7 restart strobes", n_strobe, 1);
    check("R7 restart kind", kind_log[0], 2'b01);

    // R7: stop returns to idle
    clear_log();
    bus_start();
    send_byte(8'h5A, -1, ack);
    bus_stop();
    send_byte(8'h9C, -1, ack);
    check("R7 no ack after stop", ack, 1'b0);
    check("R7 strobes after stop", n_strobe, 1);
    bus_stop();

    // R4: busy polling
    clear_log();
    busy = 1'b1;
    bus_start();
    send_byte(8'h5A, -1, ack); check("R4 busy addr nack", ack, 1'b0);
    send_byte(8'h9C, -1, ack); check("R4 busy cmd ignored", ack, 1'b0);
    bus_stop();
    busy = 1'b0;
    bus_start();
    send_byte(8'h5A, -1, ack); check("R4 ready addr ack", ack, 1'b1);
    bus_stop();
    check("R4 poll strobes", n_strobe, 1);

    // R10: short SCL glitch ignored
    clear_log();
    bus_start();
    send_byte(8'h5A, 3, ack);
    check("R10 glitch addr ack", ack, 1'b1);
    bus_stop();
    check("R10 glitch strobes", n_strobe, 1);
    check("R10 glitch byte", byte_log[0], 8'h5A);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule